// File: doc/BRIEF.md
# Programmable Color Space Converter

This block sits in a pixel pipeline. It takes one 24-bit RGB pixel per clock, qualified by a valid flag. When conversion is switched on, it multiplies the three input channels by a 3x4 affine matrix: three weights and one additive offset for each output channel. It then rounds each result, saturates it to 8 bits and sends the three channels out in a selectable order.

The matrix comes from one of three sources:
- a hard-wired standard-definition luma/colour-difference preset;
- a hard-wired high-definition preset;
- a custom bank of coefficients loaded through a simple register write port.

All register writes go into shadow copies. The shadow copies become active together on a start-of-frame pulse, so no pixel is ever computed with a mix of old and new settings. The channel reorder stays in force when conversion is off. This lets the block act as a pure channel swizzler.

Pixel channels are packed with channel 0 in bits 23:16, channel 1 in bits 15:8 and channel 2 in bits 7:0, on both input and output.

Top module: `csc_core`

## Requirements
- R1: After reset, `pix_valid_o` is low and the active settings are all zero. A pixel therefore passes through unchanged until a new setting is committed.
- R2: Every pixel appears on `pix_o` exactly two clock cycles after it is presented, with `pix_valid_o` following `pix_valid_i` delayed by two cycles. Back-to-back pixels come out on consecutive cycles.
- R3: The control word is at address 0x40: bit 0 = enable, bit 1 = RGB-to-YCC direction, bits 3:2 = mode, bits 5:4 = output order. The custom bank occupies 0x44, 0x48, 0x4C, 0x50, 0x54 and 0x58, holding entry pairs (12,11), (14,13), (22,21), (24,23), (32,31) and (34,33), with the higher-numbered entry in bits 31:16. Entry rc is output row r and input column c. Columns 1 to 3 weight input channels 0 to 2, and column 4 is the row offset.
- R4: Writes change only the shadow copies. A commit pulse on `sof_i` copies all of them to the active set at that clock edge. A pixel presented in the same cycle as the pulse still uses the old settings, and the next pixel uses the new ones.
- R5: Conversion happens only when both enable and direction are 1. Otherwise each output channel equals an input channel, moved only by the order field.
- R6: Order 0 keeps channels (c0,c1,c2). Order 1 outputs (c2,c1,c0). Order 2 outputs (c1,c2,c0). Order 3 outputs (c2,c0,c1).
- R7: Weights are 16-bit two's complement with 11 fraction bits (0x800 = 1.0). Offsets carry 4 fraction bits in output units (0x100 = 16). Each row computes sum(weight*input) + (offset << 7) + 1024, shifted arithmetically right by 11, so exact halves round up.
- R8: Rounded results below 0 give 0, and results above 255 give 255.
- R9: Mode 0 is the standard-definition preset. Rows (Y, Pb, Pr) use weights (612, 1202, 234), (-346, -678, 1024) and (1024, -858, -166), with offsets 0, 0x800 and 0x800. White maps to 0xFF8080 and pure red to 0x4C55FF.
- R10: Mode 1 is the high-definition preset. Rows use weights (435, 1465, 148), (-235, -789, 1024) and (1024, -930, -94), with offsets 0, 0x800 and 0x800. Red maps to 0x3663FF and blue to 0x12FF74.
- R11: Mode 2 is reserved and applies the identity matrix, so the pixel is unchanged apart from the reorder.
- R12: Mode 3 uses the custom bank. A limited-range matrix of 0x6E0 on the anti-diagonal with offsets 0x100, combined with order 1, maps 255 to 235 and 0 to 16 in each channel while keeping the channel positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame pulse; commits the shadow settings |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| pix_valid_i | input | 1 | Input pixel qualifier |
| pix_i | input | 24 | Input pixel, channel 0 in the top byte |
| pix_valid_o | output | 1 | Output pixel qualifier |
| pix_o | output | 24 | Output pixel, channel 0 in the top byte |

## Verification
The assertions check the following on every cycle:
- the two-cycle delay of the valid flag;
- that an unreordered bypass pixel equals the input from two cycles earlier;
- that active settings move only on a commit pulse;
- that the order applied at the output is the one that was active when the pixel entered.

Several behaviours are shown only by the bench's scenarios: the numeric results of the presets and the custom bank, the round-half-up rule, saturation at both ends, the entry placement within the bank words, and the exact cycle at which a commit takes hold relative to a pixel.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int CH_W      = 8;
  localparam int NCH       = 3;
  localparam int PIX_W     = CH_W * NCH;
  localparam int COEF_W    = 16;
  localparam int FRAC      = 11;
  localparam int OFS_FRAC  = 4;
  localparam int OFS_SHIFT = FRAC - OFS_FRAC;
  localparam int ACC_W     = COEF_W + CH_W + 8;
  localparam int NCOL      = NCH + 1;
  localparam int BANK_N    = (NCH * NCOL) / 2;
  localparam int CH_MAX    = (1 << CH_W) - 1;

  typedef logic [COEF_W-1:0] coef_t;
  typedef coef_t [0:NCOL-1] row_t;
  typedef row_t  [0:NCH-1]  mat_t;

  typedef enum logic [1:0] {
    MODE_SD     = 2'd0,
    MODE_HD     = 2'd1,
    MODE_IDENT  = 2'd2,
    MODE_CUSTOM = 2'd3
  } mode_e;

  typedef struct packed {
    logic [1:0] order;
    mode_e      mode;
    logic       dir;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1 << (FRAC - 1));

  // Hard-wired matrices; the custom mode never reads this result.
  function automatic mat_t preset(input mode_e m);
    mat_t r;
    r = '0;
    case (m)
      MODE_SD: begin
        r[0][0] = 16'(612);  r[0][1] = 16'(1202); r[0][2] = 16'(234);
        r[1][0] = 16'(-346); r[1][1] = 16'(-678); r[1][2] = 16'(1024); r[1][3] = 16'h0800;
        r[2][0] = 16'(1024); r[2][1] = 16'(-858); r[2][2] = 16'(-166); r[2][3] = 16'h0800;
      end
      MODE_HD: begin
        r[0][0] = 16'(435);  r[0][1] = 16'(1465); r[0][2] = 16'(148);
        r[1][0] = 16'(-235); r[1][1] = 16'(-789); r[1][2] = 16'(1024); r[1][3] = 16'h0800;
        r[2][0] = 16'(1024); r[2][1] = 16'(-930); r[2][2] = 16'(-94);  r[2][3] = 16'h0800;
      end
      MODE_IDENT: begin
        for (int i = 0; i < NCH; i++) r[i][i] = 16'h0800;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  // Round half up, drop the fraction, saturate to one channel.
  function automatic logic [CH_W-1:0] sat_round(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] t;
    t = (acc + HALF_LSB) >>> FRAC;
    if (t < 0)           return '0;
    else if (t > CH_MAX) return '1;
    else                 return t[CH_W-1:0];
  endfunction
endpackage

// File: rtl/csc_regs.sv
module csc_regs
  import csc_pkg::*;
#(
  parameter int ADDR_W             = 8,
  parameter int unsigned CTRL_ADDR = 'h40,
  parameter int unsigned BANK_ADDR = 'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              commit,
  output ctrl_t             ctrl_act,
  output mat_t              bank_mat
);
  ctrl_t ctrl_shd;
  logic  ctrl_hit;

  assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_shd <= '0;
      ctrl_act <= '0;
    end else begin
      if (commit)   ctrl_act <= ctrl_shd;
      if (ctrl_hit) ctrl_shd <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  // One shadow/active word per entry pair; word i feeds row i/2.
  for (genvar i = 0; i < BANK_N; i++) begin : g_bank
    logic [31:0] shd_w, act_w;
    logic        hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(BANK_ADDR + 4 * i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shd_w <= '0;
        act_w <= '0;
      end else begin
        if (commit) act_w <= shd_w;
        if (hit)    shd_w <= wr_data;
      end
    end

    assign bank_mat[i/2][(i%2)*2]     = act_w[15:0];
    assign bank_mat[i/2][(i%2)*2 + 1] = act_w[31:16];
  end
endmodule

// File: rtl/csc_mac.sv
module csc_mac
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  ctrl_t            ctrl,
  input  mat_t             bank,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix,
  output logic [1:0]       out_order,
  output logic             out_bypass
);
  mat_t m_sel;
  logic conv_on;

  always_comb m_sel = (ctrl.mode == MODE_CUSTOM) ? bank : preset(ctrl.mode);
  assign conv_on = ctrl.en & ctrl.dir;

  // Stage 1: products and scaled offsets.
  logic signed [ACC_W-1:0] s1_prod [NCH][NCH];
  logic signed [ACC_W-1:0] s1_ofs  [NCH];
  logic                    s1_valid, s1_bypass;
  logic [1:0]              s1_order;
  logic [PIX_W-1:0]        s1_pix;

  always_ff @(posedge clk) begin
    for (int r = 0; r < NCH; r++) begin
      for (int c = 0; c < NCH; c++) begin
        s1_prod[r][c] <= ACC_W'($signed(m_sel[r][c])) *
                         ACC_W'($signed({1'b0, in_pix[PIX_W-1-c*CH_W -: CH_W]}));
      end
      s1_ofs[r] <= ACC_W'($signed(m_sel[r][NCH])) <<< OFS_SHIFT;
    end
    s1_pix    <= in_pix;
    s1_bypass <= !conv_on;
    s1_order  <= ctrl.order;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  // Stage 2: sum, round, saturate, select.
  logic signed [ACC_W-1:0] sum [NCH];
  logic [PIX_W-1:0]        conv_pix;

  always_comb begin
    for (int r = 0; r < NCH; r++) begin
      sum[r] = s1_ofs[r];
      for (int c = 0; c < NCH; c++) sum[r] = sum[r] + s1_prod[r][c];
      conv_pix[PIX_W-1-r*CH_W -: CH_W] = sat_round(sum[r]);
    end
  end

  always_ff @(posedge clk) begin
    out_pix    <= s1_bypass ? s1_pix : conv_pix;
    out_order  <= s1_order;
    out_bypass <= s1_bypass;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid;
  end
endmodule

// File: rtl/csc_reorder.sv
module csc_reorder
  import csc_pkg::*;
(
  input  logic [1:0]       order,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] pix_out
);
  always_comb begin
    int src;
    for (int k = 0; k < NCH; k++) begin
      case (order)
        2'd0:    src = k;
        2'd1:    src = NCH - 1 - k;
        2'd2:    src = (k + 1) % NCH;
        default: src = (k + NCH - 1) % NCH;
      endcase
      pix_out[PIX_W-1-k*CH_W -: CH_W] = pix_in[PIX_W-1-src*CH_W -: CH_W];
    end
  end
endmodule

// File: rtl/csc_core.sv
module csc_core
  import csc_pkg::*;
#(
  parameter int ADDR_W             = 8,
  parameter int unsigned CTRL_ADDR = 'h40,
  parameter int unsigned BANK_ADDR = 'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_o
);
  ctrl_t            ctrl_act;
  mat_t             bank_mat;
  logic             commit_evt;
  logic [PIX_W-1:0] s2_pix;
  logic [1:0]       s2_order;
  logic             s2_bypass;

  assign commit_evt = sof_i;

  csc_regs #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .BANK_ADDR(BANK_ADDR)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_i),
    .wr_addr (reg_addr_i),
    .wr_data (reg_wdata_i),
    .commit  (commit_evt),
    .ctrl_act(ctrl_act),
    .bank_mat(bank_mat)
  );

  csc_mac u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pix_valid_i),
    .in_pix    (pix_i),
    .ctrl      (ctrl_act),
    .bank      (bank_mat),
    .out_valid (pix_valid_o),
    .out_pix   (s2_pix),
    .out_order (s2_order),
    .out_bypass(s2_bypass)
  );

  csc_reorder u_ord (
    .order  (s2_order),
    .pix_in (s2_pix),
    .pix_out(pix_o)
  );
endmodule

// File: rtl/csc_chk.sv
module csc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        commit_evt,
  input logic        pix_valid_i,
  input logic [23:0] pix_i,
  input logic        pix_valid_o,
  input logic [23:0] pix_o,
  input logic [5:0]  ctrl_act,
  input logic [1:0]  s2_order,
  input logic        s2_bypass
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2: valid flag is delayed by exactly two cycles.
  p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (pix_valid_o == $past(pix_valid_i, 2)));

  // R5: bypass with order 0 returns the input pixel unchanged.
  p_bypass_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && pix_valid_o && s2_bypass && s2_order == 2'd0)
      |-> (pix_o == $past(pix_i, 2)));

  // R4: active settings move only on a commit pulse.
  p_hold_no_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(ctrl_act));

  // R6: the order at the output is the one active when the pixel entered.
  p_order_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && pix_valid_o) |-> (s2_order == $past(ctrl_act[5:4], 2)));
endmodule

bind csc_core csc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .commit_evt (commit_evt),
  .pix_valid_i(pix_valid_i),
  .pix_i      (pix_i),
  .pix_valid_o(pix_valid_o),
  .pix_o      (pix_o),
  .ctrl_act   (ctrl_act),
  .s2_order   (s2_order),
  .s2_bypass  (s2_bypass)
);

// File: tb/tb_csc_core.sv
`timescale 1ns/1ps
module tb_csc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        pix_valid_i = 1'b0;
  logic [23:0] pix_i = '0;
  logic        pix_valid_o;
  logic [23:0] pix_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  csc_core dut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .pix_valid_i(pix_valid_i), .pix_i(pix_i),
    .pix_valid_o(pix_valid_o), .pix_o(pix_o)
  );

  // {control word, input pixel, expected pixel}
  localparam int NV = 14;
  localparam logic [79:0] VEC [NV] = '{
    {32'h00, 24'h123456, 24'h123456},  // R5 off
    {32'h10, 24'h123456, 24'h563412},  // R6 order 1
    {32'h20, 24'h123456, 24'h345612},  // R6 order 2
    {32'h30, 24'h123456, 24'h561234},  // R6 order 3
    {32'h01, 24'h123456, 24'h123456},  // R5 enable without direction
    {32'h03, 24'hFFFFFF, 24'hFF8080},  // R9 white
    {32'h03, 24'hFF0000, 24'h4C55FF},  // R9 red, top clamp
    {32'h03, 24'h000000, 24'h008080},  // R9 black
    {32'h07, 24'hFF0000, 24'h3663FF},  // R10 red
    {32'h07, 24'h0000FF, 24'h12FF74},  // R10 blue
    {32'h0B, 24'h123456, 24'h123456},  // R11 identity
    {32'h1F, 24'hFF0080, 24'hEB107E},  // R12 mixed
    {32'h1F, 24'h000000, 24'h101010},  // R12 zero -> 16
    {32'h1F, 24'hFFFFFF, 24'hEBEBEB}   // R12 full -> 235
  };
  localparam string VREQ [NV] = '{"R5", "R6", "R6", "R6", "R5", "R9", "R9",
                                  "R9", "R10", "R10", "R11", "R3/R12", "R12", "R12"};

  task automatic chk(input string req, input logic [24:0] act, input logic [24:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic commit();
    sof_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0;
  endtask

  task automatic send(input string req, input logic [23:0] p, input logic [23:0] exp);
    pix_valid_i = 1'b1; pix_i = p;
    @(negedge clk);
    pix_valid_i = 1'b0;
    @(negedge clk);
    chk(req, {pix_valid_o, pix_o}, {1'b1, exp});
  endtask

  initial begin
    #(200000 * 8);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {24'd0, pix_valid_o}, 25'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {24'd0, pix_valid_o}, 25'd0);
    send("R1", 24'hA1B2C3, 24'hA1B2C3);

    // R4: shadow write is invisible until the commit pulse.
    wr_reg(8'h40, 32'h10);
    send("R4", 24'h0A0B0C, 24'h0A0B0C);
    commit();
    send("R4", 24'h0A0B0C, 24'h0C0B0A);

    // R4: pixel in the commit cycle uses old settings, the next one new.
    wr_reg(8'h40, 32'h00);
    sof_i = 1'b1; pix_valid_i = 1'b1; pix_i = 24'h112233;
    @(negedge clk);
    sof_i = 1'b0; pix_i = 24'h445566;
    @(negedge clk);
    pix_valid_i = 1'b0;
    chk("R4", {pix_valid_o, pix_o}, {1'b1, 24'h332211});
    @(negedge clk);
    chk("R4", {pix_valid_o, pix_o}, {1'b1, 24'h445566});

    // R2: back-to-back pixels, two-cycle latency.
    pix_valid_i = 1'b1; pix_i = 24'h010203;
    @(negedge clk);
    chk("R2", {24'd0, pix_valid_o}, 25'd0);
    pix_i = 24'h040506;
    @(negedge clk);
    chk("R2", {pix_valid_o, pix_o}, {1'b1, 24'h010203});
    pix_i = 24'h070809;
    @(negedge clk);
    pix_valid_i = 1'b0;
    chk("R2", {pix_valid_o, pix_o}, {1'b1, 24'h040506});
    @(negedge clk);
    chk("R2", {pix_valid_o, pix_o}, {1'b1, 24'h070809});
    @(negedge clk);
    chk("R2", {24'd0, pix_valid_o}, 25'd0);

    // R3: limited-range custom bank.
    wr_reg(8'h44, 32'h0000_0000);
    wr_reg(8'h48, 32'h0100_06E0);
    wr_reg(8'h4C, 32'h06E0_0000);
    wr_reg(8'h50, 32'h0100_0000);
    wr_reg(8'h54, 32'h0000_06E0);
    wr_reg(8'h58, 32'h0100_0000);

    for (int i = 0; i < NV; i++) begin
      wr_reg(8'h40, VEC[i][79:48]);
      commit();
      send(VREQ[i], VEC[i][47:24], VEC[i][23:0]);
    end

    // R7 rounding and R8 clamping: row1 = 0.5*c0, row2 = offset 1.5, row3 = -c0.
    wr_reg(8'h44, 32'h0000_0400);
    wr_reg(8'h48, 32'h0000_0000);
    wr_reg(8'h4C, 32'h0000_0000);
    wr_reg(8'h50, 32'h0018_0000);
    wr_reg(8'h54, 32'h0000_F800);
    wr_reg(8'h58, 32'h0000_0000);
    wr_reg(8'h40, 32'h0F);
    commit();
    send("R7", 24'h030000, 24'h020200);
    send("R7", 24'h010000, 24'h010200);
    send("R7", 24'h000000, 24'h000200);
    wr_reg(8'h44, 32'h0000_1000);
    commit();
    send("R8", 24'hC80000, 24'hFF0200);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule